// File: doc/BRIEF.md
# ISA I/O Port Decoder with Write Strobe Shaping

This block connects an 8-bit ISA-style I/O bus to a motion-controller chip. It watches the bus address, the address-enable line and the I/O read and write strobes. It claims a 16-address window whose base is chosen by a two-bit select input, from the four bases 340h, 350h, 370h and 390h. Inside that window the low four address bits pick one of four functions: a data port, a command port, a one-bit status port and a software reset port. All other offsets are silent.

Toward the controller it drives an active-low chip-select and a read strobe, both formed directly from the bus signals. It also passes on a command/data select. The write strobe is shaped in step with a local clock. It goes active for exactly one clock after a qualifying bus write is seen. It then stays off until the bus write strobe is released, which gives the controller data hold time before the bus cycle ends. A status read returns the controller's ready flag on data bit 7 only. The controller reset is active while the bus reset line is held, and for a fixed number of clocks after a write to the reset port.

Top module: `isa_port_decoder`

## Requirements
- R1: base_sel values 0, 1, 2 and 3 place the window at 340h, 350h, 370h and 390h. An address whose bits 9..4 match another base, or no base, is not decoded.
- R2: ctl_cs_n is low exactly when the window matches and address bits 3 and 2 are both 0 (offsets 0h..3h).
- R3: While bus_aen is 1, no decode happens: ctl_cs_n is high, ctl_rd_n is high, d7_oe is 0, and no write strobe or software reset begins.
- R4: ctl_rd_n is low in the same cycle in which ctl_cs_n is low and bus_ior_n is low. It is high otherwise, with no clock delay.
- R5: ctl_cmd follows address bit 1. It is 1 for offset 2h (command) and 0 for offset 0h (data).
- R6: ctl_wr_n goes low for exactly one clock. It starts at the first rising clock edge that samples ctl_cs_n low together with bus_iow_n low.
- R7: After a write strobe, no new strobe is issued until bus_iow_n has been sampled high, even if the write stays asserted.
- R8: A read at offset 4h drives d7_oe to 1, with d7_out equal to ctl_ready. Reads at any other offset, and writes to offset 4h, leave d7_oe at 0. No other data bit is ever driven.
- R9: A write to offset 8h drives ctl_rst_n low for SRST_CYCLES clocks (2 by default). The pulse starts at the first edge that samples the write, and it is not restarted while the same write is held. The write also clears the write-strobe state, so a following write is strobed even though bus_iow_n never went high.
- R10: bus_rst drives ctl_rst_n low in the same cycle, for as long as bus_rst is held, and it resets the write-strobe and pulse state.
- R11: Accesses to offsets 5h..7h and 9h..Fh give no chip-select, no read or write strobe, no reset pulse and no drive on d7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock that samples the bus strobes |
| bus_rst | input | 1 | Bus reset, active high; synchronous reset of the block |
| base_sel | input | SEL_W | Window base select |
| bus_addr | input | ADDR_W | Bus I/O address |
| bus_aen | input | 1 | Bus address enable; high during DMA cycles |
| bus_ior_n | input | 1 | Bus I/O read strobe, active low |
| bus_iow_n | input | 1 | Bus I/O write strobe, active low |
| ctl_ready | input | 1 | Controller ready flag |
| ctl_cs_n | output | 1 | Controller chip-select, active low |
| ctl_rd_n | output | 1 | Controller read strobe, active low |
| ctl_wr_n | output | 1 | Shaped controller write strobe, active low |
| ctl_cmd | output | 1 | Command (1) / data (0) select |
| ctl_rst_n | output | 1 | Controller reset, active low |
| d7_out | output | 1 | Value for data bit 7 during a status read |
| d7_oe | output | 1 | Output enable for data bit 7 |

## Verification
The bench builds the block with its default parameters. These are the 340h/350h/370h/390h base table, a 10-bit address and a two-clock software reset. The bench sweeps all four base_sel values, so each window can be seen matching while the other three are refused. The two-clock pulse length lets the bench hold the reset write across its whole pulse, which shows that the pulse does not restart. It also lets the bench start a new write inside the pulse, which shows that the toggle state was cleared.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;
  localparam int OFF_W = 4;

  localparam logic [OFF_W-1:0] OFF_DATA = 4'h0;
  localparam logic [OFF_W-1:0] OFF_CMD  = 4'h2;
  localparam logic [OFF_W-1:0] OFF_STAT = 4'h4;
  localparam logic [OFF_W-1:0] OFF_SRST = 4'h8;

  typedef struct packed {
    logic             hit;
    logic [OFF_W-1:0] off;
  } win_dec_t;
endpackage

// File: rtl/isa_base_decode.sv
module isa_base_decode
  import isa_dec_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SEL_W  = 2,
  parameter logic [(1<<SEL_W)-1:0][ADDR_W-1:0] BASES =
    {10'h390, 10'h370, 10'h350, 10'h340}
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              aen,
  output win_dec_t          dec
);
  localparam int NUM_BASES = 1 << SEL_W;

  logic [NUM_BASES-1:0] match;

  // one comparator per selectable base; sel picks the result
  for (genvar i = 0; i < NUM_BASES; i++) begin : g_base
    assign match[i] = (addr[ADDR_W-1:OFF_W] == BASES[i][ADDR_W-1:OFF_W]);
  end

  always_comb begin
    dec.hit = match[sel] && !aen;
    dec.off = addr[OFF_W-1:0];
  end
endmodule

// File: rtl/isa_wr_shaper.sv
module isa_wr_shaper (
  input  logic clk,
  input  logic clr,
  input  logic req,
  input  logic iow_n,
  output logic wr_n
);
  logic wr_act;
  logic tog;

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_act <= 1'b0;
      tog    <= 1'b0;
    end else begin
      wr_act <= req && !wr_act && !tog;
      tog    <= (wr_act || tog) && !iow_n;
    end
  end

  assign wr_n = !wr_act;
endmodule

// File: rtl/isa_rst_pulse.sv
module isa_rst_pulse #(
  parameter int CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          trig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig;
      if (trig && !trig_q)
        cnt <= CW'(CYCLES);
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/isa_port_decoder.sv
module isa_port_decoder
  import isa_dec_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SEL_W       = 2,
  parameter int SRST_CYCLES = 2,
  parameter logic [(1<<SEL_W)-1:0][ADDR_W-1:0] BASES =
    {10'h390, 10'h370, 10'h350, 10'h340}
) (
  input  logic              clk,
  input  logic              bus_rst,
  input  logic [SEL_W-1:0]  base_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_aen,
  input  logic              bus_ior_n,
  input  logic              bus_iow_n,
  input  logic              ctl_ready,
  output logic              ctl_cs_n,
  output logic              ctl_rd_n,
  output logic              ctl_wr_n,
  output logic              ctl_cmd,
  output logic              ctl_rst_n,
  output logic              d7_out,
  output logic              d7_oe
);
  win_dec_t dec;
  logic     cs;
  logic     srst_hit;
  logic     srst_busy;
  logic     wr_clr;

  isa_base_decode #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .BASES(BASES)
  ) u_dec (
    .sel (base_sel),
    .addr(bus_addr),
    .aen (bus_aen),
    .dec (dec)
  );

  // offsets 0..3 belong to the controller
  assign cs       = dec.hit && (dec.off[OFF_W-1:2] == '0);
  assign ctl_cs_n = !cs;
  assign ctl_rd_n = !(cs && !bus_ior_n);
  assign ctl_cmd  = bus_addr[1];

  assign d7_oe  = dec.hit && (dec.off == OFF_STAT) && !bus_ior_n;
  assign d7_out = ctl_ready;

  assign srst_hit = dec.hit && (dec.off == OFF_SRST) && !bus_iow_n;
  assign wr_clr   = bus_rst || srst_hit;

  isa_wr_shaper u_wr (
    .clk  (clk),
    .clr  (wr_clr),
    .req  (cs && !bus_iow_n),
    .iow_n(bus_iow_n),
    .wr_n (ctl_wr_n)
  );

  isa_rst_pulse #(.CYCLES(SRST_CYCLES)) u_rst (
    .clk (clk),
    .rst (bus_rst),
    .trig(srst_hit),
    .busy(srst_busy)
  );

  assign ctl_rst_n = !(bus_rst || srst_busy);
endmodule

// File: rtl/isa_port_decoder_chk.sv
module isa_port_decoder_chk (
  input logic clk,
  input logic bus_rst,
  input logic bus_aen,
  input logic bus_ior_n,
  input logic bus_iow_n,
  input logic ctl_cs_n,
  input logic ctl_rd_n,
  input logic ctl_wr_n,
  input logic ctl_rst_n,
  input logic d7_oe
);
  // set once the bus write strobe has been released (or a reset cleared state)
  logic armed;
  always_ff @(posedge clk) begin
    if (bus_rst)                     armed <= 1'b1;
    else if (bus_iow_n || !ctl_rst_n) armed <= 1'b1;
    else if (!ctl_wr_n)              armed <= 1'b0;
  end

  a_r3_aen_blocks: assert property (@(posedge clk) disable iff (bus_rst)
    bus_aen |-> (ctl_cs_n && !d7_oe));

  a_r4_rd_needs_cs: assert property (@(posedge clk) disable iff (bus_rst)
    !ctl_rd_n |-> (!ctl_cs_n && !bus_ior_n));

  a_r6_one_clock: assert property (@(posedge clk) disable iff (bus_rst)
    !ctl_wr_n |=> ctl_wr_n);

  a_r6_cause: assert property (@(posedge clk) disable iff (bus_rst)
    $fell(ctl_wr_n) |-> $past(!ctl_cs_n && !bus_iow_n));

  a_r7_rearm: assert property (@(posedge clk) disable iff (bus_rst)
    $fell(ctl_wr_n) |-> armed);

  a_r8_stat_exclusive: assert property (@(posedge clk) disable iff (bus_rst)
    d7_oe |-> (ctl_cs_n && !bus_ior_n));

  a_r10_bus_reset: assert property (@(posedge clk)
    bus_rst |-> !ctl_rst_n);
endmodule

bind isa_port_decoder isa_port_decoder_chk u_chk (.*);

// File: tb/tb_isa_port_decoder.sv
`timescale 1ns/1ps
module tb_isa_port_decoder;
  localparam logic [6:0] M_CS  = 7'h40;
  localparam logic [6:0] M_RD  = 7'h20;
  localparam logic [6:0] M_WR  = 7'h10;
  localparam logic [6:0] M_CMD = 7'h08;
  localparam logic [6:0] M_RST = 7'h04;
  localparam logic [6:0] M_OE  = 7'h02;
  localparam logic [6:0] M_D7  = 7'h01;

  typedef struct {
    logic [6:0] mask;
    logic [6:0] val;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       bus_rst = 1'b1;
  logic [1:0] base_sel = 2'd0;
  logic [9:0] bus_addr = '0;
  logic       bus_aen = 1'b0;
  logic       bus_ior_n = 1'b1;
  logic       bus_iow_n = 1'b1;
  logic       ctl_ready = 1'b0;
  logic ctl_cs_n, ctl_rd_n, ctl_wr_n, ctl_cmd, ctl_rst_n, d7_out, d7_oe;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  exp_t q[$];
  logic [9:0] bases [4] = '{10'h340, 10'h350, 10'h370, 10'h390};

  always #4 clk = ~clk;

  isa_port_decoder dut (.*);

  // monitor: one expectation per cycle, compared half a period after the edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [6:0] obs;
      e   = q.pop_front();
      obs = {ctl_cs_n, ctl_rd_n, ctl_wr_n, ctl_cmd, ctl_rst_n, d7_oe, d7_out};
      if (e.mask != '0) begin
        n_cmp++;
        if ((obs & e.mask) !== (e.val & e.mask)) begin
          n_bad++;
          $display("FAIL %s: actual=%b expected=%b mask=%b (cs,rd,wr,cmd,rst,oe,d7)",
                   e.tag, obs, e.val, e.mask);
        end
      end
    end
  end

  // driver: apply one cycle of bus inputs and queue what the outputs must be
  task automatic go(input logic [9:0] a, input logic ior_n, input logic iow_n,
                    input logic rst, input logic rdy,
                    input logic [6:0] m, input logic [6:0] v, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    bus_addr  = a;
    bus_ior_n = ior_n;
    bus_iow_n = iow_n;
    bus_rst   = rst;
    ctl_ready = rdy;
    e.mask = m; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] b;
    // R10 reset state
    go(10'h000, 1, 1, 1, 0, M_CS|M_WR|M_RST, M_CS|M_WR, "R10 reset state");
    go(10'h000, 1, 1, 1, 0, M_RST, 7'h00, "R10 reset held");
    go(10'h000, 1, 1, 0, 0, M_RST|M_WR, M_RST|M_WR, "R10 reset released");

    // R1 R2 R4 R5 across all base selects
    for (int s = 0; s < 4; s++) begin
      base_sel = 2'(s);
      b = bases[s];
      go(b,       0, 1, 0, 0, M_CS|M_RD|M_CMD|M_OE, 7'h00, "R1 data read at base");
      go(b + 2,   0, 1, 0, 0, M_CS|M_RD|M_CMD, M_CMD, "R5 command select");
      go(b + 3,   1, 1, 0, 0, M_CS|M_RD, M_RD, "R4 cs without ior");
      go(bases[(s+1)%4], 0, 1, 0, 0, M_CS|M_RD, M_CS|M_RD, "R1 other base refused");
      go(b - 10'h10, 0, 1, 0, 0, M_CS|M_RD, M_CS|M_RD, "R2 below window");
    end
    base_sel = 2'd0;
    b = bases[0];

    // R3 address enable blocks decode
    bus_aen = 1'b1;
    go(b,     0, 1, 0, 1, M_CS|M_RD, M_CS|M_RD, "R3 aen blocks read");
    go(b + 4, 0, 1, 0, 1, M_OE, 7'h00, "R3 aen blocks status");
    go(b,     1, 0, 0, 1, M_CS, M_CS, "R3 aen blocks write");
    go(b,     1, 0, 0, 1, M_WR, M_WR, "R3 no strobe under aen");
    go(b + 8, 1, 0, 0, 1, M_RST, M_RST, "R3 no reset under aen");
    go(b + 8, 1, 1, 0, 1, M_RST, M_RST, "R3 no reset under aen later");
    bus_aen = 1'b0;

    // R8 status port
    go(b + 4, 0, 1, 0, 1, M_OE|M_D7|M_CS|M_RD, M_OE|M_D7|M_CS|M_RD, "R8 status ready=1");
    go(b + 4, 0, 1, 0, 0, M_OE|M_D7, M_OE, "R8 status ready=0");
    go(b + 4, 1, 0, 0, 1, M_OE, 7'h00, "R8 write to status undriven");
    go(b,     0, 1, 0, 1, M_OE, 7'h00, "R8 data read no d7 drive");

    // R6 R7 write shaping
    go(b,     1, 1, 0, 0, M_WR, M_WR, "R6 idle");
    go(b,     1, 0, 0, 0, M_CS|M_WR, M_WR, "R6 strobe not before edge");
    go(b,     1, 0, 0, 0, M_WR, 7'h00, "R6 strobe one clock");
    go(b,     1, 0, 0, 0, M_WR, M_WR, "R7 held off");
    go(b,     1, 0, 0, 0, M_WR, M_WR, "R7 still held off");
    go(b,     1, 1, 0, 0, M_WR, M_WR, "R7 write ends");
    go(b + 2, 1, 0, 0, 0, M_WR|M_CMD, M_WR|M_CMD, "R6 second write pending");
    go(b + 2, 1, 0, 0, 0, M_WR|M_CMD, M_CMD, "R6 second strobe");
    go(b + 2, 1, 1, 0, 0, M_WR, M_WR, "R6 second strobe ends");
    go(b,     1, 0, 0, 0, M_WR, M_WR, "R6 short write pending");
    go(b,     1, 1, 0, 0, M_WR, 7'h00, "R6 short write strobe");
    go(b,     1, 1, 0, 0, M_WR, M_WR, "R6 short write done");

    // R9 software reset pulse, held write does not restart it
    go(b + 8, 1, 0, 0, 0, M_RST|M_CS|M_WR, M_RST|M_CS|M_WR, "R9 reset not before edge");
    go(b + 8, 1, 0, 0, 0, M_RST, 7'h00, "R9 pulse clock 1");
    go(b + 8, 1, 1, 0, 0, M_RST, 7'h00, "R9 pulse clock 2");
    go(b + 8, 1, 1, 0, 0, M_RST, M_RST, "R9 pulse ends");
    go(b,     1, 1, 0, 0, M_RST, M_RST, "R9 no restart");

    // R9 reset write clears write state while iow stays low
    go(b,     1, 0, 0, 0, M_WR, M_WR, "R9 prewrite pending");
    go(b,     1, 0, 0, 0, M_WR, 7'h00, "R9 prewrite strobe");
    go(b + 8, 1, 0, 0, 0, M_WR|M_RST, M_WR|M_RST, "R9 toggle holding");
    go(b,     1, 0, 0, 0, M_WR|M_RST, M_WR, "R9 cleared, pulse on");
    go(b,     1, 1, 0, 0, M_WR|M_RST, 7'h00, "R9 strobe after clear");
    go(b,     1, 1, 0, 0, M_WR|M_RST, M_WR|M_RST, "R9 quiet after clear");

    // R11 unused offsets
    go(b + 5,     0, 1, 0, 1, M_CS|M_RD|M_OE, M_CS|M_RD, "R11 read offset 5");
    go(b + 7,     0, 1, 0, 1, M_CS|M_RD|M_OE, M_CS|M_RD, "R11 read offset 7");
    go(b + 9,     0, 1, 0, 1, M_CS|M_RD|M_OE, M_CS|M_RD, "R11 read offset 9");
    go(b + 10'hF, 0, 1, 0, 1, M_CS|M_RD|M_OE, M_CS|M_RD, "R11 read offset F");
    go(b + 6,     1, 0, 0, 0, M_CS, M_CS, "R11 write offset 6");
    go(b + 6,     1, 0, 0, 0, M_WR|M_RST, M_WR|M_RST, "R11 offset 6 no strobe");
    go(b + 9,     1, 0, 0, 0, M_WR|M_RST, M_WR|M_RST, "R11 write offset 9");
    go(b + 9,     1, 0, 0, 0, M_WR|M_RST, M_WR|M_RST, "R11 offset 9 no reset");
    go(b + 10'hC, 1, 0, 0, 0, M_WR|M_RST, M_WR|M_RST, "R11 write offset C");
    go(b + 10'hC, 1, 1, 0, 0, M_WR|M_RST, M_WR|M_RST, "R11 offset C no reset");

    // R10 bus reset mid-write, then clean write afterwards
    go(b,     1, 0, 0, 0, M_WR, M_WR, "R10 write pending");
    go(b,     1, 0, 1, 0, M_RST|M_WR, 7'h00, "R10 reset asserts at once");
    go(b,     1, 0, 1, 0, M_RST|M_WR, M_WR, "R10 reset holds");
    go(b,     1, 1, 0, 0, M_RST|M_WR, M_RST|M_WR, "R10 reset released quiet");
    go(b,     1, 0, 0, 0, M_WR, M_WR, "R10 new write pending");
    go(b,     1, 1, 0, 0, M_WR, 7'h00, "R10 new write strobe");

    go(10'h000, 1, 1, 0, 0, 7'h00, 7'h00, "drain");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule